// File: doc/BRIEF.md
# Flash Read Timing Calibration Sequencer

This block finds the fastest dependable serial-flash read clock and the matching input sampling delay, without software in the loop. After a start pulse it reads a fixed flash region once in a slow, plain reference mode. It keeps only a CRC-32 signature of that region. It then walks the clock divisors from the slowest candidate to the fastest. Divisors that would run above the allowed frequency are skipped. For each divisor that is not skipped, it sweeps a ladder of sampling-delay settings. Each setting gets repeated reads, and every read is judged against the reference signature.

The winning delay code for each divisor is written into that divisor's own 4-bit field of a timing word. The flash controller reads this word while it serves each request. When the sweep completes, the smallest divisor that found a safe delay window is reported. A read error from the controller stops the search at once and raises an error flag. The flash controller that actually drives the pins sits outside this block. It serves each request by streaming the region back one byte per valid beat.

Top module: `cal_seq`

## Requirements
- R1: Reset state: `busy_o`, `done_o`, `err_o`, `rd_req_o` are 0, and `div_o` and `timing_o` are all zero.
- R2: A start pulse seen while idle is followed first by a reference read of the region. During that read `rd_div_o` is 0, which asks the controller for its slow, single-bit, plain-read, divide-by-16, no-dummy setting.
- R3: Divisors are tried in the order 5, 4, 3, 2, 1. Divisor d is skipped when `bus_hz_i >= max_hz_i * d`. A skipped divisor issues no read and leaves its timing field untouched.
- R4: Delay indices 0..11 are tried in ascending order. The code for index i is `{i even, i/2}`: bit 3 is set for even i and bits 2:0 hold i/2. The code for divisor d lives at bits `4*(d-1)+3 : 4*(d-1)` of `timing_o`, and a write changes only that field.
- R5: A setting passes only after 10 consecutive reads whose signature equals the reference. The first mismatching read fails the setting, and no further read of that setting is issued.
- R6: A pass adds one to a run counter and a fail clears it. When the counter reaches 3 at index i, the field of the current divisor receives the code of index i-1, and that divisor's sweep ends.
- R7: A divisor whose sweep ends without such a run is not a candidate. Its field keeps the code of index 11, the last setting tried.
- R8: At completion `div_o` holds the smallest divisor that succeeded, or 0 if none did. A value of 0 means the controller stays at divide-by-16. `div_o` changes only together with `done_o`.
- R9: `rd_err_i` during a read ends the run at once. `done_o` pulses, `err_o` becomes 1, `div_o` becomes 0, and no further request is issued. `err_o` is cleared by the next accepted start.
- R10: `done_o` is a single-cycle pulse issued with `busy_o` low. A start pulse while busy is ignored.
- R11: `rd_req_o` is a single-cycle pulse issued only while busy. Exactly LEN valid bytes are taken per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a calibration run (honoured only when idle) |
| bus_hz_i | input | FREQ_W | Bus clock frequency in Hz |
| max_hz_i | input | FREQ_W | Highest allowed flash clock in Hz |
| rd_req_o | output | 1 | One-cycle request for a read of the region |
| rd_div_o | output | DW | Divisor to use for the request; 0 selects the slow reference mode |
| rd_err_i | input | 1 | Controller reports a failed read |
| rd_vld_i | input | 1 | A region byte is presented |
| rd_data_i | input | 8 | Region byte |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Last run was aborted by a read error |
| div_o | output | DW | Chosen divisor, 0 for none |
| timing_o | output | 4*N_DIV | Per-divisor delay-code fields |

## Verification
Two functions can land on the same clock edge. The first is the completion of the last byte of a read whose signature decides a pass. The second is the jump that follows: to the next index, to the next divisor, or to the end, each of which also rewrites a timing field. The bench provokes this edge with a flash model that corrupts a chosen repetition of a chosen setting. In particular it corrupts the tenth read, where the pass and the counter reset collide. It judges the outcome by the total number of requests issued, the final field values and the reported divisor, all computed from the requirements. A second collision, a start pulse arriving while busy, is injected mid-run and must leave the results unchanged.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_RD,
        S_DIV,
        S_FIN
    } cal_state_e;

    // Sampling-delay code: bit 3 adds the fixed input delay on even indices.
    function automatic logic [CODE_W-1:0] dly_code(input logic [3:0] idx);
        return {~idx[0], idx[3:1]};
    endfunction

endpackage

// File: rtl/cal_crc_step.sv
module cal_crc_step #(
    parameter logic [31:0] POLY = 32'hEDB8_8320
) (
    input  logic [31:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [31:0] crc_o
);
    always_comb begin
        logic [31:0] c;
        c = crc_i ^ {24'd0, byte_i};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        crc_o = c;
    end
endmodule

// File: rtl/cal_div_gate.sv
module cal_div_gate #(
    parameter int FREQ_W = 32,
    parameter int DW     = 3
) (
    input  logic [FREQ_W-1:0] bus_hz_i,
    input  logic [FREQ_W-1:0] max_hz_i,
    input  logic [DW-1:0]     div_i,
    output logic              too_fast_o
);
    localparam int PW = FREQ_W + DW;
    logic [PW-1:0] limit;

    // bus/div >= max  <=>  bus >= max*div (no divider needed)
    assign limit      = PW'(max_hz_i) * PW'(div_i);
    assign too_fast_o = PW'(bus_hz_i) >= limit;
endmodule

// File: rtl/cal_seq.sv
module cal_seq
    import cal_pkg::*;
#(
    parameter int LEN     = 16,
    parameter int FREQ_W  = 32,
    parameter int N_DIV   = 5,
    parameter int N_IDX   = 12,
    parameter int N_REP   = 10,
    parameter int RUN_LEN = 3,
    localparam int DW     = $clog2(N_DIV + 1),
    localparam int TW     = N_DIV * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] bus_hz_i,
    input  logic [FREQ_W-1:0] max_hz_i,
    output logic              rd_req_o,
    output logic [DW-1:0]     rd_div_o,
    input  logic              rd_err_i,
    input  logic              rd_vld_i,
    input  logic [7:0]        rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DW-1:0]     div_o,
    output logic [TW-1:0]     timing_o
);
    localparam int IW = $clog2(N_IDX);
    localparam int RW = $clog2(N_REP);
    localparam int PW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam int BW = (LEN > 1) ? $clog2(LEN) : 1;

    typedef struct packed {
        cal_state_e     st;
        logic           ref_ph;
        logic [DW-1:0]  div;
        logic [IW-1:0]  idx;
        logic [RW-1:0]  rep;
        logic [PW-1:0]  run;
        logic [BW-1:0]  cnt;
        logic [31:0]    crc;
        logic [31:0]    refsig;
        logic [DW-1:0]  best;
        logic [DW-1:0]  res;
        logic [TW-1:0]  tim;
        logic           done;
        logic           err;
    } regs_t;

    regs_t q, n;

    logic [31:0]       crc_nx;
    logic              too_fast;
    logic              wr;
    logic [CODE_W-1:0] wcode;
    logic              adv_idx;
    logic              adv_div;

    cal_crc_step u_crc (
        .crc_i  (q.crc),
        .byte_i (rd_data_i),
        .crc_o  (crc_nx)
    );

    cal_div_gate #(.FREQ_W(FREQ_W), .DW(DW)) u_gate (
        .bus_hz_i   (bus_hz_i),
        .max_hz_i   (max_hz_i),
        .div_i      (q.div),
        .too_fast_o (too_fast)
    );

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        wr      = 1'b0;
        wcode   = '0;
        adv_idx = 1'b0;
        adv_div = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    n.st     = S_REQ;
                    n.ref_ph = 1'b1;
                    n.err    = 1'b0;
                    n.best   = '0;
                end
            end
            S_REQ: begin
                n.st  = S_RD;
                n.cnt = '0;
                n.crc = 32'hFFFF_FFFF;
            end
            S_RD: begin
                if (rd_err_i) begin
                    n.st   = S_IDLE;
                    n.done = 1'b1;
                    n.err  = 1'b1;
                    n.res  = '0;
                end else if (rd_vld_i) begin
                    n.crc = crc_nx;
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == BW'(LEN - 1)) begin
                        if (q.ref_ph) begin
                            n.refsig = crc_nx;
                            n.ref_ph = 1'b0;
                            n.div    = DW'(N_DIV);
                            n.st     = S_DIV;
                        end else if (crc_nx != q.refsig) begin
                            n.run   = '0;
                            n.rep   = '0;
                            adv_idx = 1'b1;
                        end else if (q.rep == RW'(N_REP - 1)) begin
                            n.rep = '0;
                            if (q.run == PW'(RUN_LEN - 1)) begin
                                wr      = 1'b1;
                                wcode   = dly_code(4'(q.idx - 1'b1));
                                n.best  = q.div;
                                adv_div = 1'b1;
                            end else begin
                                n.run   = q.run + 1'b1;
                                adv_idx = 1'b1;
                            end
                        end else begin
                            n.rep = q.rep + 1'b1;
                            n.st  = S_REQ;
                        end
                    end
                end
            end
            S_DIV: begin
                if (too_fast) begin
                    adv_div = 1'b1;
                end else begin
                    n.idx = '0;
                    n.run = '0;
                    n.rep = '0;
                    wr    = 1'b1;
                    wcode = dly_code(4'd0);
                    n.st  = S_REQ;
                end
            end
            S_FIN: begin
                n.done = 1'b1;
                n.res  = q.best;
                n.st   = S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase

        if (adv_idx) begin
            if (q.idx == IW'(N_IDX - 1)) begin
                adv_div = 1'b1;
            end else begin
                n.idx = q.idx + 1'b1;
                wr    = 1'b1;
                wcode = dly_code(4'(q.idx + 1'b1));
                n.st  = S_REQ;
            end
        end

        if (adv_div) begin
            if (q.div == DW'(1)) begin
                n.st = S_FIN;
            end else begin
                n.div = q.div - 1'b1;
                n.st  = S_DIV;
            end
        end

        for (int f = 0; f < N_DIV; f++) begin
            if (wr && q.div == DW'(f + 1)) begin
                n.tim[f*CODE_W +: CODE_W] = wcode;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    assign rd_req_o = (q.st == S_REQ);
    assign rd_div_o = q.ref_ph ? '0 : q.div;
    assign busy_o   = (q.st != S_IDLE);
    assign done_o   = q.done;
    assign err_o    = q.err;
    assign div_o    = q.res;
    assign timing_o = q.tim;

endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
    parameter int N_DIV = 5,
    parameter int DW    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_req_o,
    input logic                busy_o,
    input logic                done_o,
    input logic                err_o,
    input logic [DW-1:0]       div_o,
    input logic [N_DIV*4-1:0]  timing_o
);
    logic [N_DIV*4-1:0] tim_prev;
    logic [N_DIV-1:0]   chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tim_prev <= '0;
        else        tim_prev <= timing_o;
    end

    always_comb begin
        for (int f = 0; f < N_DIV; f++) begin
            chg[f] = (timing_o[f*4 +: 4] != tim_prev[f*4 +: 4]);
        end
    end

    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
    assert_req_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> busy_o);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_err_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);
    assert_one_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg));
    assert_field_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |-> busy_o);
    assert_div_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_o) |-> done_o);
    assert_div_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(div_o) <= N_DIV);
endmodule

bind cal_seq cal_seq_chk #(.N_DIV(N_DIV), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req_o (rd_req_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .div_o    (div_o),
    .timing_o (timing_o)
);

// File: tb/cal_seq_tb.sv
module cal_seq_tb;
    localparam int LEN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] bus_hz_i = '0;
    logic [31:0] max_hz_i = '0;
    logic        rd_req_o;
    logic [2:0]  rd_div_o;
    logic        rd_err_i = 1'b0;
    logic        rd_vld_i = 1'b0;
    logic [7:0]  rd_data_i = '0;
    logic        busy_o, done_o, err_o;
    logic [2:0]  div_o;
    logic [19:0] timing_o;

    cal_seq #(.LEN(LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .bus_hz_i(bus_hz_i), .max_hz_i(max_hz_i),
        .rd_req_o(rd_req_o), .rd_div_o(rd_div_o), .rd_err_i(rd_err_i),
        .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .div_o(div_o), .timing_o(timing_o)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int fail_rep [1:5][0:11];   // 10 = always passes, else failing repetition
    int err_at = 0;
    int req_n = 0;
    int first_div = -1;
    int pat = 0;
    logic [19:0] tim_model = '0;

    task automatic chk(input string req, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int bcode(input int i);
        return ((i % 2 == 0) ? 8 : 0) | (i / 2);
    endfunction

    // flash model
    initial begin
        int last_key = -1;
        int rep = 0;
        forever begin
            @(negedge clk);
            rd_vld_i = 1'b0;
            rd_err_i = 1'b0;
            if (rd_req_o) begin
                int d, code, idx, key, bad;
                req_n++;
                d = int'(rd_div_o);
                if (req_n == 1) first_div = d;
                bad = 0;
                if (d == 0) begin
                    last_key = -1;
                end else begin
                    code = int'(timing_o[(d-1)*4 +: 4]);
                    idx  = (code & 7) * 2 + (((code & 8) != 0) ? 0 : 1);
                    key  = d * 16 + idx;
                    if (key == last_key) rep++;
                    else begin rep = 0; last_key = key; end
                    if (idx < 12 && fail_rep[d][idx] == rep) bad = 1;
                end
                if (err_at != 0 && req_n == err_at) begin
                    @(negedge clk);
                    rd_err_i = 1'b1;
                end else begin
                    for (int k = 0; k < LEN; k++) begin
                        @(negedge clk);
                        rd_vld_i  = 1'b1;
                        rd_data_i = 8'(k * 29 + 5 + pat);
                        if (bad != 0 && k == rep % LEN) rd_data_i = rd_data_i ^ 8'h10;
                    end
                end
            end
        end
    end

    task automatic fill_map(input int pct);
        for (int d = 1; d <= 5; d++)
            for (int i = 0; i < 12; i++)
                fail_rep[d][i] = (($urandom % 100) < pct) ? 10 : int'($urandom % 10);
    endtask

    task automatic model(input longint bus, input longint mx, output int reqs,
                         output int best, output logic [19:0] tim);
        reqs = 1; best = 0; tim = tim_model;
        for (int d = 5; d >= 1; d--) begin
            int run, won;
            if (bus >= mx * d) continue;
            run = 0; won = 0;
            for (int i = 0; i < 12; i++) begin
                tim[(d-1)*4 +: 4] = 4'(bcode(i));
                if (fail_rep[d][i] < 10) begin
                    reqs += fail_rep[d][i] + 1;
                    run = 0;
                end else begin
                    reqs += 10;
                    run++;
                    if (run == 3) begin
                        tim[(d-1)*4 +: 4] = 4'(bcode(i - 1));
                        best = d; won = 1;
                        break;
                    end
                end
            end
        end
    endtask

    task automatic do_run(input int bus, input int mx, input int errn,
                          input int restart, input string tag);
        int er, eb;
        logic [19:0] et;
        bus_hz_i = 32'(bus); max_hz_i = 32'(mx);
        err_at = errn; req_n = 0; first_div = -1; pat++;
        model(bus, mx, er, eb, et);
        if (errn != 0) begin er = errn; eb = 0; end
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (restart != 0) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;              // R10: ignored while busy
            @(negedge clk); start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        chk({"R10 busy low at done ", tag}, busy_o, 0);
        chk({"R2 reference read first ", tag}, first_div, 0);
        chk({"R5 request count ", tag}, req_n, er);
        chk({"R8 chosen divisor ", tag}, div_o, eb);
        chk({"R9 error flag ", tag}, err_o, (errn != 0) ? 1 : 0);
        if (errn == 0) begin
            chk({"R6 timing fields ", tag}, timing_o, et);
            tim_model = et;
        end
        @(negedge clk);
        chk({"R10 done pulse width ", tag}, done_o, 0);
        repeat (3) @(negedge clk);
        chk({"R11 no request after run ", tag}, req_n, er);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", busy_o, 0);
        chk("R1 done at reset", done_o, 0);
        chk("R1 err at reset", err_o, 0);
        chk("R1 req at reset", rd_req_o, 0);
        chk("R1 div at reset", div_o, 0);
        chk("R1 timing at reset", timing_o, 0);
        rst_n = 1'b1;
        tim_model = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R3/R8: all pass, only divisors 5 and 4 allowed
        fill_map(100);
        do_run(400_000_000, 104_000_000, 0, 0, "allpass");

        // R3 boundary: bus/3 == max is skipped
        fill_map(100);
        do_run(300_000_000, 100_000_000, 0, 0, "equal");

        // R7: nothing passes; fields hold index 11 code
        fill_map(0);
        do_run(200_000_000, 300_000_000, 0, 0, "nopass");

        // R3: everything skipped, timing unchanged
        do_run(400_000_000, 50_000_000, 0, 0, "allskip");

        // R5/R6: mismatch on the tenth read breaks a run
        fill_map(100);
        fail_rep[5][1] = 9;
        fail_rep[4][3] = 0;
        do_run(200_000_000, 300_000_000, 0, 0, "rep9");

        // R10: start while busy
        fill_map(80);
        do_run(250_000_000, 120_000_000, 0, 1, "restart");

        // R9: read error aborts
        fill_map(100);
        do_run(200_000_000, 300_000_000, 5, 0, "abort");
        do_reset();

        for (int r = 0; r < 8; r++) begin
            int bus, mx;
            fill_map(70);
            bus = 100_000_000 + int'($urandom % 400_000_000);
            mx  = 40_000_000 + int'($urandom % 160_000_000);
            do_run(bus, mx, 0, 0, "random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule